// File: doc/BRIEF.md
# Transfer Descriptor Slot Scheduler

This block arbitrates among a bank of transfer-descriptor slots of one transfer class. Software loads a set of slot bitmaps over a small register bus: which slots hold work, which slots are to be passed over, which slot closes the pass, and two interrupt masks. Once software sets the buffer-filled control bit, the block walks the eligible slots in ascending index order and offers one slot at a time to an execution engine on a request/grant handshake.

The engine reports each finished slot with a one-cycle done pulse. The block then retires that slot and records it in a done map. An interrupt pulse is raised when a finished slot is named in the any-of mask, or when every slot named in the all-of mask has finished. A chip with isochronous, periodic and asynchronous traffic places one instance per class. Each instance has its own maps, masks and buffer-filled bit.

Top module: `tds_sched`

## Requirements
- R1: After reset, every register reads 0, `req_o` is low and `irq_o` is low.
- R2: The register map is: address 0 work map, 1 skip map, 2 closing-slot map, 3 any-of mask, 4 all-of mask, 5 done map, 6 control (bit 0 = buffer filled). Maps 0 to 4 and the control register read back the last value written. The done map is write-1-to-clear.
- R3: `req_o` is high only while buffer-filled is 1 and at least one slot is eligible. A slot is eligible when its work bit is 1, its skip bit is 0 and it lies inside the pass window. The offered slot is the lowest eligible index at or above the scan pointer. If no eligible index lies at or above the pointer, the offered slot is the lowest eligible index overall.
- R4: A slot whose skip bit is 1 is never offered, even when its work bit is 1.
- R5: The pass window runs from slot 0 to the lowest slot whose closing bit is set, or to the top slot when no closing bit is set. Slots above the closing slot are never offered.
- R6: Writing control bit 0 to 1 while buffer-filled is 0 restarts the scan at slot 0.
- R7: A grant (`req_o` and `gnt_i` both high at a clock edge) moves the pointer one past the granted slot. It moves the pointer to 0 when the granted slot is the closing slot or the top slot. While no slot is eligible, `req_o` is low and the pointer does not move.
- R8: A done pulse clears the work bit of its slot and sets that slot's done-map bit. In the same cycle, the done pulse wins over a register write to either map.
- R9: A done pulse for a slot set in the any-of mask produces a one-cycle `irq_o` pulse in the following cycle.
- R10: When the done map first covers a nonzero all-of mask, `irq_o` pulses once in the following cycle. It fires again only after software clears a covered done bit and the mask becomes fully covered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Read data for `reg_raddr` (combinational) |
| req_o | output | 1 | A slot is offered to the engine |
| slot_o | output | 5 | Index of the offered slot |
| gnt_i | input | 1 | Engine accepts the offered slot |
| done_i | input | 1 | One-cycle pulse: a slot has finished |
| done_slot_i | input | 5 | Index of the finished slot |
| irq_o | output | 1 | One-cycle completion interrupt pulse |

## Verification
The hardest state to reach is a scan pointer that has been parked while nothing was eligible. The pointer is only visible through the order in which slots are later offered. The stimulus grants a slot to leave the pointer mid-bank and then empties the work map while holding grant high. It then reloads a map whose lowest slot sits below the parked pointer, so a moved or reset pointer shows up as a different first slot. A second subtle case is the one-shot all-of interrupt. The stimulus repeats a done pulse on an already covered slot, then clears a single covered done bit and completes the slot again, to show that the interrupt re-arms only through that path.

// File: rtl/tds_pkg.sv
package tds_pkg;
   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_WORK  = 3'd0,
      RA_SKIP  = 3'd1,
      RA_CLOSE = 3'd2,
      RA_ANY   = 3'd3,
      RA_ALL   = 3'd4,
      RA_DONE  = 3'd5,
      RA_CTRL  = 3'd6
   } reg_addr_e;
endpackage

// File: rtl/tds_regs.sv
module tds_regs
   import tds_pkg::*;
#(
   parameter int unsigned NSLOT = 32,
   parameter int unsigned DW    = 32,
   localparam int unsigned SW   = $clog2(NSLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [REG_AW-1:0] waddr_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic [REG_AW-1:0] raddr_i,
   output logic [DW-1:0]     rdata_o,
   input  logic              done_i,
   input  logic [SW-1:0]     done_slot_i,
   output logic [NSLOT-1:0]  work_o,
   output logic [NSLOT-1:0]  skip_o,
   output logic [NSLOT-1:0]  close_o,
   output logic [NSLOT-1:0]  any_o,
   output logic [NSLOT-1:0]  all_nxt_o,
   output logic [NSLOT-1:0]  done_map_o,
   output logic [NSLOT-1:0]  done_nxt_o,
   output logic              fill_o,
   output logic              start_o
);
   localparam logic [NSLOT-1:0] ONE = NSLOT'(1);

   logic [NSLOT-1:0] work_q, skip_q, close_q, any_q, all_q, done_q;
   logic [NSLOT-1:0] work_n, all_n, done_n, hot;
   logic             fill_q;

   function automatic logic hit(input logic we, input logic [REG_AW-1:0] a, input reg_addr_e r);
      return we && (a == r);
   endfunction

   assign hot = done_i ? (ONE << done_slot_i) : '0;

   always_comb begin
      work_n = work_q;
      if (hit(we_i, waddr_i, RA_WORK)) work_n = wdata_i[NSLOT-1:0];
      work_n = work_n & ~hot;

      done_n = done_q;
      if (hit(we_i, waddr_i, RA_DONE)) done_n = done_n & ~wdata_i[NSLOT-1:0];
      done_n = done_n | hot;

      all_n = all_q;
      if (hit(we_i, waddr_i, RA_ALL)) all_n = wdata_i[NSLOT-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q  <= '0;
         skip_q  <= '0;
         close_q <= '0;
         any_q   <= '0;
         all_q   <= '0;
         done_q  <= '0;
         fill_q  <= 1'b0;
      end else begin
         work_q <= work_n;
         done_q <= done_n;
         all_q  <= all_n;
         if (hit(we_i, waddr_i, RA_SKIP))  skip_q  <= wdata_i[NSLOT-1:0];
         if (hit(we_i, waddr_i, RA_CLOSE)) close_q <= wdata_i[NSLOT-1:0];
         if (hit(we_i, waddr_i, RA_ANY))   any_q   <= wdata_i[NSLOT-1:0];
         if (hit(we_i, waddr_i, RA_CTRL))  fill_q  <= wdata_i[0];
      end
   end

   assign start_o = hit(we_i, waddr_i, RA_CTRL) && wdata_i[0] && !fill_q;

   always_comb begin
      case (raddr_i)
         RA_WORK:  rdata_o = DW'(work_q);
         RA_SKIP:  rdata_o = DW'(skip_q);
         RA_CLOSE: rdata_o = DW'(close_q);
         RA_ANY:   rdata_o = DW'(any_q);
         RA_ALL:   rdata_o = DW'(all_q);
         RA_DONE:  rdata_o = DW'(done_q);
         RA_CTRL:  rdata_o = DW'(fill_q);
         default:  rdata_o = '0;
      endcase
   end

   assign work_o     = work_q;
   assign skip_o     = skip_q;
   assign close_o    = close_q;
   assign any_o      = any_q;
   assign all_nxt_o  = all_n;
   assign done_map_o = done_q;
   assign done_nxt_o = done_n;
   assign fill_o     = fill_q;

   // R8: a finished slot is retired and recorded
   p_done_retires_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && (done_slot_i < SW'(NSLOT - 1) || done_slot_i == SW'(NSLOT - 1)))
      |=> (!work_q[$past(done_slot_i)] && done_q[$past(done_slot_i)]));
endmodule

// File: rtl/tds_picker.sv
module tds_picker #(
   parameter int unsigned NSLOT = 32,
   localparam int unsigned SW   = $clog2(NSLOT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSLOT-1:0] work_i,
   input  logic [NSLOT-1:0] skip_i,
   input  logic [NSLOT-1:0] close_i,
   input  logic             fill_i,
   input  logic             start_i,
   input  logic             gnt_i,
   output logic             req_o,
   output logic [SW-1:0]    slot_o
);
   logic [SW-1:0]    ptr_q;
   logic [NSLOT-1:0] win, at_or_above, elig, upper;
   logic             wrap_here;

   function automatic logic [SW-1:0] lowest(input logic [NSLOT-1:0] v);
      logic [SW-1:0] r;
      r = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (v[i]) r = SW'(i);
      end
      return r;
   endfunction

   always_comb begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
         win[i] = ~seen;
         seen   = seen | close_i[i];
      end
   end

   for (genvar g = 0; g < NSLOT; g++) begin : g_ge
      assign at_or_above[g] = (ptr_q <= SW'(g));
   end

   assign elig      = work_i & ~skip_i & win;
   assign upper     = elig & at_or_above;
   assign slot_o    = (|upper) ? lowest(upper) : lowest(elig);
   assign req_o     = fill_i && (|elig);
   assign wrap_here = close_i[slot_o] || (slot_o == SW'(NSLOT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (start_i) begin
         ptr_q <= '0;
      end else if (req_o && gnt_i) begin
         ptr_q <= wrap_here ? '0 : slot_o + 1'b1;
      end
   end

   // R7: no grant, no movement
   p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!(req_o && gnt_i) && !start_i) |=> $stable(ptr_q));

   // R6: buffer-filled rising restarts at slot 0
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (ptr_q == '0));
endmodule

// File: rtl/tds_irq.sv
module tds_irq #(
   parameter int unsigned NSLOT = 32,
   localparam int unsigned SW   = $clog2(NSLOT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_i,
   input  logic [SW-1:0]    done_slot_i,
   input  logic [NSLOT-1:0] any_i,
   input  logic [NSLOT-1:0] all_nxt_i,
   input  logic [NSLOT-1:0] done_nxt_i,
   output logic             irq_o
);
   localparam logic [NSLOT-1:0] ONE = NSLOT'(1);

   logic any_hit, full_n, full_q, irq_q;

   assign any_hit = done_i && (|((ONE << done_slot_i) & any_i));
   assign full_n  = (|all_nxt_i) && ((done_nxt_i & all_nxt_i) == all_nxt_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         full_q <= full_n;
         irq_q  <= any_hit | (full_n & ~full_q);
      end
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/tds_sched.sv
module tds_sched
   import tds_pkg::*;
#(
   parameter int unsigned NSLOT = 32,
   parameter int unsigned DW    = 32,
   localparam int unsigned SW   = $clog2(NSLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_waddr,
   input  logic [DW-1:0]     reg_wdata,
   input  logic [REG_AW-1:0] reg_raddr,
   output logic [DW-1:0]     reg_rdata,
   output logic              req_o,
   output logic [SW-1:0]     slot_o,
   input  logic              gnt_i,
   input  logic              done_i,
   input  logic [SW-1:0]     done_slot_i,
   output logic              irq_o
);
   if (NSLOT < 2 || NSLOT > DW) begin : g_bad_cfg
      $error("tds_sched: NSLOT must lie in 2..DW");
   end

   logic [NSLOT-1:0] work, skip, close, any, all_nxt, done_map, done_nxt;
   logic             fill, start;

   tds_regs #(.NSLOT(NSLOT), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .we_i(reg_we), .waddr_i(reg_waddr), .wdata_i(reg_wdata),
      .raddr_i(reg_raddr), .rdata_o(reg_rdata),
      .done_i(done_i), .done_slot_i(done_slot_i),
      .work_o(work), .skip_o(skip), .close_o(close), .any_o(any),
      .all_nxt_o(all_nxt), .done_map_o(done_map), .done_nxt_o(done_nxt),
      .fill_o(fill), .start_o(start)
   );

   tds_picker #(.NSLOT(NSLOT)) u_pick (
      .clk(clk), .rst_n(rst_n),
      .work_i(work), .skip_i(skip), .close_i(close),
      .fill_i(fill), .start_i(start), .gnt_i(gnt_i),
      .req_o(req_o), .slot_o(slot_o)
   );

   tds_irq #(.NSLOT(NSLOT)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .done_i(done_i), .done_slot_i(done_slot_i),
      .any_i(any), .all_nxt_i(all_nxt), .done_nxt_i(done_nxt),
      .irq_o(irq_o)
   );

   // R4: offered slot holds work and is not skipped
   p_offer_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> (work[slot_o] && !skip[slot_o]));

   // R5: no closing bit below the offered slot
   p_offer_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> ((close & ~({NSLOT{1'b1}} << slot_o)) == '0));

   // R9: any-of hit yields interrupt next cycle
   p_any_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && any[done_slot_i]) |=> irq_o);

   // R10: interrupt without an any-of hit needs a covered all-of mask
   p_all_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !$past(done_i && any[done_slot_i]))
      |-> ((done_map & $past(all_nxt)) == $past(all_nxt)));
endmodule

// File: tb/tds_sched_tb_top.sv
`timescale 1ns/100ps
module tds_sched_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_waddr = '0;
   logic [31:0] reg_wdata = '0;
   logic [2:0]  reg_raddr = '0;
   logic [31:0] reg_rdata;
   logic        req_o;
   logic [4:0]  slot_o;
   logic        gnt_i = 1'b0;
   logic        done_i = 1'b0;
   logic [4:0]  done_slot_i = '0;
   logic        irq_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit closed = 0;
   logic [4:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   tds_sched dut_i (.*);

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string rq);
      reg_raddr = a; #0.5;
      chk(rq, reg_rdata, exp);
   endtask

   task automatic expect_slot(input logic [4:0] s, input string rq);
      exp_q.push_back(s);
      tag_q.push_back(rq);
   endtask

   task automatic grant_n(input int n);
      @(posedge clk); #1;
      gnt_i = 1'b1;
      repeat (n) @(posedge clk);
      #1 gnt_i = 1'b0;
   endtask

   task automatic done_pulse(input logic [4:0] s, input logic exp_irq, input string rq);
      @(posedge clk); #1;
      done_i = 1'b1; done_slot_i = s;
      @(posedge clk); #1;
      done_i = 1'b0;
      @(negedge clk);
      chk(rq, 32'(irq_o), 32'(exp_irq));
      @(negedge clk);
      chk(rq, 32'(irq_o), 32'd0);
   endtask

   // monitor: compare every grant against the scoreboard
   always @(negedge clk) begin
      if (rst_n && req_o && gnt_i) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R3 actual=%0d expected=<no grant>", slot_o);
         end else begin
            automatic logic [4:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (slot_o !== e) begin
               n_bad++;
               $display("FAIL %s actual=%0d expected=%0d", t, slot_o, e);
            end
         end
      end
   end

   task automatic finish_run();
      if (!closed) begin
         closed = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 req", 32'(req_o), 32'd0);
      chk("R1 irq", 32'(irq_o), 32'd0);
      for (int a = 0; a < 7; a++) rd(3'(a), 32'd0, "R1 regs");

      // R2 readback
      wr(3'd1, 32'hA5A5_0000); rd(3'd1, 32'hA5A5_0000, "R2 skip");
      wr(3'd3, 32'h1234_5678); rd(3'd3, 32'h1234_5678, "R2 any");
      wr(3'd4, 32'h0F0F_0000); rd(3'd4, 32'h0F0F_0000, "R2 all");
      wr(3'd2, 32'h8000_0000); rd(3'd2, 32'h8000_0000, "R2 close");
      wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, 32'd0, "R2 done w1c");
      wr(3'd1, 0); wr(3'd3, 0); wr(3'd4, 0); wr(3'd2, 0);

      // R3 basic scan with wrap after top slot (R5)
      wr(3'd0, 32'h8000_00F1);
      @(negedge clk); chk("R3 req without fill", 32'(req_o), 32'd0);
      wr(3'd6, 32'd1); rd(3'd6, 32'd1, "R2 ctrl");
      expect_slot(0, "R3"); expect_slot(4, "R3"); expect_slot(5, "R3");
      expect_slot(6, "R3"); expect_slot(7, "R3"); expect_slot(31, "R5 top");
      expect_slot(0, "R5 wrap"); expect_slot(4, "R3");
      grant_n(8);

      // R4 skip slot 5, pointer is at 5
      wr(3'd1, 32'h0000_0020);
      expect_slot(6, "R4"); expect_slot(7, "R4"); expect_slot(31, "R4");
      expect_slot(0, "R4"); expect_slot(4, "R4");
      grant_n(5);

      // R5 closing slot 4
      wr(3'd2, 32'h0000_0010);
      expect_slot(0, "R5"); expect_slot(4, "R5");
      expect_slot(0, "R5 close wrap"); expect_slot(4, "R5");
      grant_n(4);

      // R7 idle hold: pointer parked at 1
      wr(3'd2, 0);
      expect_slot(0, "R7");
      grant_n(1);
      wr(3'd0, 0);
      @(posedge clk); #1 gnt_i = 1'b1;
      repeat (4) begin
         @(negedge clk); chk("R7 idle req", 32'(req_o), 32'd0);
      end
      @(posedge clk); #1 gnt_i = 1'b0;
      wr(3'd0, 32'h0000_0003);
      expect_slot(1, "R7 held pointer");
      grant_n(1);

      // R6 restart at 0
      wr(3'd6, 0);
      @(negedge clk); chk("R3 req fill off", 32'(req_o), 32'd0);
      wr(3'd6, 32'd1);
      expect_slot(0, "R6 restart");
      grant_n(1);

      // R8 done retires slot
      done_pulse(5'd0, 1'b0, "R9 no any hit");
      rd(3'd0, 32'h0000_0002, "R8 work cleared");
      rd(3'd5, 32'h0000_0001, "R8 done set");
      wr(3'd5, 32'h0000_0001); rd(3'd5, 32'd0, "R8 w1c");
      @(posedge clk); #1;
      done_i = 1'b1; done_slot_i = 5'd1;
      reg_we = 1'b1; reg_waddr = 3'd5; reg_wdata = 32'h0000_0002;
      @(posedge clk); #1;
      done_i = 1'b0; reg_we = 1'b0;
      rd(3'd5, 32'h0000_0002, "R8 set wins");
      rd(3'd0, 32'd0, "R8 work empty");
      @(negedge clk); chk("R8 req after retire", 32'(req_o), 32'd0);
      wr(3'd5, 32'hFFFF_FFFF);

      // R9 any-of interrupt
      wr(3'd3, 32'h0000_0100);
      done_pulse(5'd3, 1'b0, "R9 miss");
      done_pulse(5'd8, 1'b1, "R9 hit");
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd3, 0);

      // R10 all-of interrupt
      wr(3'd4, 32'h0000_0C00);
      done_pulse(5'd10, 1'b0, "R10 partial");
      done_pulse(5'd11, 1'b1, "R10 covered");
      done_pulse(5'd10, 1'b0, "R10 no rearm");
      wr(3'd5, 32'h0000_0800);
      @(negedge clk); chk("R10 clear", 32'(irq_o), 32'd0);
      done_pulse(5'd11, 1'b1, "R10 refire");

      chk("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule